// File: doc/BRIEF.md
# Sequentially Loaded Three-Channel Input Gamma Table

This block holds a 256-entry lookup table for each of the red, green and blue channels of a pixel stream. Each entry is a 12-bit unsigned fraction (u0.12). When the table path is selected, the block maps every incoming 12-bit channel value through its own channel's table. When bypass is selected, the pixel passes through unchanged. Both paths have the same fixed latency of one clock.

The table is loaded through a single data port. Software first writes a start index. It then writes colour data words, and a channel pointer steps red, green, blue, then moves on to the next index. A 3-bit write mask picks which channel memories accept the data. A memory power-on control must be held high for any load to take effect. The table is normally loaded with the mask at 3'b111 and the index at 0, followed by 768 data writes.

Top module: `gamma_lut_seq`

## Requirements
- R1: After reset, pix_vld_o is 0, all three output channels are 0, the load index is 0 and the channel pointer is at red.
- R2: A pulse on idx_we loads idx_wdata into the load index and returns the channel pointer to red, even in the middle of a red/green/blue triple.
- R3: With cfg_pwr_on at 1, each seq_we pulse writes seq_wdata to the channel under the pointer at the current index. The pointer steps in the order red (0), green (1), blue (2). After the blue write the index increases by one, wrapping from 255 to 0, and the pointer returns to red.
- R4: cfg_wr_mask bit 0 enables red, bit 1 enables green and bit 2 enables blue. A data write to a channel whose mask bit is 0 leaves that channel's memory unchanged but still advances the pointer and index as in R3.
- R5: While cfg_pwr_on is 0, seq_we pulses change no memory, no pointer and no index.
- R6: With cfg_gamma_bypass at 0, a valid pixel yields, one clock later, each output channel equal to that channel's table entry addressed by the top 8 bits of its input. pix_vld_o is pix_vld_i delayed by one clock.
- R7: With cfg_gamma_bypass at 1, a valid pixel appears unchanged on the outputs one clock later.
- R8: In a cycle with pix_vld_i at 0, the output channel values do not change on the next clock.
- R9: When idx_we and seq_we are both high in the same cycle, the index write takes effect and the data word is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_mask | input | 3 | Per-channel load enable: bit 0 red, bit 1 green, bit 2 blue |
| cfg_pwr_on | input | 1 | Table memory powered for loading |
| cfg_gamma_bypass | input | 1 | 0 selects the table path, 1 selects pass-through |
| idx_we | input | 1 | Load-index write strobe |
| idx_wdata | input | 8 | New load index |
| seq_we | input | 1 | Sequential colour data write strobe |
| seq_wdata | input | 12 | Colour entry, u0.12 |
| pix_vld_i | input | 1 | Input pixel valid |
| pix_r_i | input | 12 | Input red |
| pix_g_i | input | 12 | Input green |
| pix_b_i | input | 12 | Input blue |
| pix_vld_o | output | 1 | Output pixel valid |
| pix_r_o | output | 12 | Output red |
| pix_g_o | output | 12 | Output green |
| pix_b_o | output | 12 | Output blue |

## Verification
A table write takes effect at the clock edge that samples the strobe, so a lookup launched in any later cycle sees the new entry. A pixel result, in either mode, appears exactly one clock after the edge that sampled the pixel. The bench drives every input on the falling edge and samples the outputs 1 ns after the rising edge that captured the stimulus. Its expected values for ignored, masked or powered-down writes come from lookups of the entries those writes could have touched.

// File: rtl/gamma_lut_seq.sv
module gamma_lut_seq #(
  parameter int IDX_W = 8,
  parameter int CW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cfg_wr_mask,
  input  logic          cfg_pwr_on,
  input  logic          cfg_gamma_bypass,
  input  logic          idx_we,
  input  logic [IDX_W-1:0] idx_wdata,
  input  logic          seq_we,
  input  logic [CW-1:0] seq_wdata,
  input  logic          pix_vld_i,
  input  logic [CW-1:0] pix_r_i,
  input  logic [CW-1:0] pix_g_i,
  input  logic [CW-1:0] pix_b_i,
  output logic          pix_vld_o,
  output logic [CW-1:0] pix_r_o,
  output logic [CW-1:0] pix_g_o,
  output logic [CW-1:0] pix_b_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [1:0] CH_LAST = 2'd2;

  logic [1:0]       ch_ptr;
  logic [IDX_W-1:0] idx;
  logic [CW-1:0]    pin [3];
  logic [CW-1:0]    q   [3];

  wire seq_go = seq_we && cfg_pwr_on && !idx_we;

  assign pin[0] = pix_r_i;
  assign pin[1] = pix_g_i;
  assign pin[2] = pix_b_i;
  assign pix_r_o = q[0];
  assign pix_g_o = q[1];
  assign pix_b_o = q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx    <= '0;
      ch_ptr <= '0;
    end else if (idx_we) begin
      idx    <= idx_wdata;
      ch_ptr <= '0;
    end else if (seq_go) begin
      if (ch_ptr == CH_LAST) begin
        ch_ptr <= '0;
        idx    <= idx + 1'b1;
      end else begin
        ch_ptr <= ch_ptr + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pix_vld_o <= 1'b0;
    else        pix_vld_o <= pix_vld_i;
  end

  for (genvar c = 0; c < 3; c++) begin : g_ch
    logic [CW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (seq_go && ch_ptr == 2'(c) && cfg_wr_mask[c])
        mem[idx] <= seq_wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        q[c] <= '0;
      else if (pix_vld_i)
        q[c] <= cfg_gamma_bypass ? pin[c] : mem[pin[c][CW-1 -: IDX_W]];
    end
  end
endmodule

module gamma_lut_seq_chk #(
  parameter int IDX_W = 8,
  parameter int CW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_pwr_on,
  input logic             cfg_gamma_bypass,
  input logic             idx_we,
  input logic [IDX_W-1:0] idx_wdata,
  input logic             seq_we,
  input logic             pix_vld_i,
  input logic [CW-1:0]    pix_r_i,
  input logic [CW-1:0]    pix_g_i,
  input logic [CW-1:0]    pix_b_i,
  input logic             pix_vld_o,
  input logic [CW-1:0]    pix_r_o,
  input logic [CW-1:0]    pix_g_o,
  input logic [CW-1:0]    pix_b_o,
  input logic [1:0]       ch_ptr,
  input logic [IDX_W-1:0] idx
);
  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_ptr != 2'd3);

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> (ch_ptr == 2'd0) && (idx == $past(idx_wdata)));

  // R3
  blue_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_we && cfg_pwr_on && !idx_we && ch_ptr == 2'd2) |=>
      (ch_ptr == 2'd0) && (idx == $past(idx) + 1'b1));

  // R5
  pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_we && !cfg_pwr_on && !idx_we) |=> $stable(ch_ptr) && $stable(idx));

  // R6
  vld_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_vld_i |=> pix_vld_o);

  // R6
  vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld_i |=> !pix_vld_o);

  // R7
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld_i && cfg_gamma_bypass) |=>
      (pix_r_o == $past(pix_r_i)) && (pix_g_o == $past(pix_g_i)) &&
      (pix_b_o == $past(pix_b_i)));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld_i |=> $stable(pix_r_o) && $stable(pix_g_o) && $stable(pix_b_o));
endmodule

bind gamma_lut_seq gamma_lut_seq_chk #(.IDX_W(IDX_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_pwr_on(cfg_pwr_on),
  .cfg_gamma_bypass(cfg_gamma_bypass), .idx_we(idx_we),
  .idx_wdata(idx_wdata), .seq_we(seq_we), .pix_vld_i(pix_vld_i),
  .pix_r_i(pix_r_i), .pix_g_i(pix_g_i), .pix_b_i(pix_b_i),
  .pix_vld_o(pix_vld_o), .pix_r_o(pix_r_o), .pix_g_o(pix_g_o),
  .pix_b_o(pix_b_o), .ch_ptr(ch_ptr), .idx(idx)
);

// File: tb/tb_gamma_lut_seq.sv
module tb_gamma_lut_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_wr_mask = 3'b111;
  logic        cfg_pwr_on = 1'b0;
  logic        cfg_gamma_bypass = 1'b0;
  logic        idx_we = 1'b0;
  logic [7:0]  idx_wdata = '0;
  logic        seq_we = 1'b0;
  logic [11:0] seq_wdata = '0;
  logic        pix_vld_i = 1'b0;
  logic [11:0] pix_r_i = '0, pix_g_i = '0, pix_b_i = '0;
  logic        pix_vld_o;
  logic [11:0] pix_r_o, pix_g_o, pix_b_o;

  int n_chk = 0, n_bad = 0;
  logic [11:0] ref_mem [3][256];
  int m_idx = 0, m_ch = 0;

  always #5 clk = ~clk;

  gamma_lut_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_mask(cfg_wr_mask),
    .cfg_pwr_on(cfg_pwr_on), .cfg_gamma_bypass(cfg_gamma_bypass),
    .idx_we(idx_we), .idx_wdata(idx_wdata), .seq_we(seq_we),
    .seq_wdata(seq_wdata), .pix_vld_i(pix_vld_i), .pix_r_i(pix_r_i),
    .pix_g_i(pix_g_i), .pix_b_i(pix_b_i), .pix_vld_o(pix_vld_o),
    .pix_r_o(pix_r_o), .pix_g_o(pix_g_o), .pix_b_o(pix_b_o)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_idx(input int v, input bit with_seq, input logic [11:0] d);
    @(negedge clk);
    idx_we = 1'b1; idx_wdata = 8'(v); seq_we = with_seq; seq_wdata = d;
    @(posedge clk); #1;
    idx_we = 1'b0; seq_we = 1'b0;
    m_idx = v; m_ch = 0;
  endtask

  task automatic wr_seq(input logic [11:0] d);
    @(negedge clk);
    seq_we = 1'b1; seq_wdata = d;
    @(posedge clk); #1;
    seq_we = 1'b0;
    if (cfg_pwr_on) begin
      if (cfg_wr_mask[m_ch]) ref_mem[m_ch][m_idx] = d;
      if (m_ch == 2) begin m_ch = 0; m_idx = (m_idx + 1) % 256; end
      else m_ch++;
    end
  endtask

  task automatic look(input logic [11:0] r, g, b, input bit byp, input string req);
    @(negedge clk);
    cfg_gamma_bypass = byp; pix_vld_i = 1'b1;
    pix_r_i = r; pix_g_i = g; pix_b_i = b;
    @(posedge clk); #1;
    chk({req, " vld"}, pix_vld_o, 1);
    chk({req, " red"},   pix_r_o, byp ? r : ref_mem[0][r[11:4]]);
    chk({req, " green"}, pix_g_o, byp ? g : ref_mem[1][g[11:4]]);
    chk({req, " blue"},  pix_b_o, byp ? b : ref_mem[2][b[11:4]]);
    @(negedge clk);
    pix_vld_i = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1 vld", pix_vld_o, 0);
    chk("R1 red", pix_r_o, 0);
    chk("R1 green", pix_g_o, 0);
    chk("R1 blue", pix_b_o, 0);
    @(negedge clk); rst_n = 1'b1;
    cfg_pwr_on = 1'b1;
    wr_seq(12'h5A5);
    look(12'h000, 12'h0FF, 12'hFFF, 1'b0, "R1 first write at index 0 red");
  endtask

  task automatic t_full_load();
    cfg_wr_mask = 3'b111;
    wr_idx(0, 1'b0, '0);
    for (int i = 0; i < 256; i++) begin
      wr_seq(12'((i * 16 + 3)));
      wr_seq(12'(4095 - i * 16));
      wr_seq(12'((i * 13)));
    end
    look(12'h000, 12'h00F, 12'h008, 1'b0, "R6 entry 0");
    look(12'hFFF, 12'hFF0, 12'hFF7, 1'b0, "R6 entry 255");
    look(12'h80A, 12'h123, 12'hC3D, 1'b0, "R6 mixed entries");
    wr_seq(12'hABC);
    look(12'h00F, 12'h001, 12'h002, 1'b0, "R3 wrap 255 to 0");
  endtask

  task automatic t_mask();
    wr_idx(5, 1'b0, '0);
    cfg_wr_mask = 3'b010;
    wr_seq(12'h111); wr_seq(12'h222); wr_seq(12'h333);
    cfg_wr_mask = 3'b111;
    wr_seq(12'h444);
    look(12'h050, 12'h05F, 12'h055, 1'b0, "R4 masked index 5");
    look(12'h060, 12'h060, 12'h060, 1'b0, "R4 pointer advanced to index 6");
  endtask

  task automatic t_power();
    wr_idx(10, 1'b0, '0);
    wr_seq(12'h701);
    cfg_pwr_on = 1'b0;
    wr_seq(12'hDEA); wr_seq(12'hDEB);
    cfg_pwr_on = 1'b1;
    wr_seq(12'h702);
    look(12'h0A0, 12'h0A0, 12'h0A0, 1'b0, "R5 powered-down writes ignored");
  endtask

  task automatic t_bypass();
    look(12'h123, 12'h456, 12'h789, 1'b1, "R7 bypass");
    look(12'hFFF, 12'h000, 12'h800, 1'b1, "R7 bypass extremes");
  endtask

  task automatic t_hold();
    look(12'h300, 12'h400, 12'h500, 1'b0, "R8 setup");
    @(negedge clk);
    pix_r_i = 12'hFFF; pix_g_i = 12'h000; pix_b_i = 12'h777; cfg_gamma_bypass = 1'b1;
    @(posedge clk); #1;
    chk("R8 vld low", pix_vld_o, 0);
    chk("R8 red held", pix_r_o, ref_mem[0][8'h30]);
    chk("R8 green held", pix_g_o, ref_mem[1][8'h40]);
    chk("R8 blue held", pix_b_o, ref_mem[2][8'h50]);
  endtask

  task automatic t_priority();
    wr_idx(20, 1'b1, 12'hBAD);
    wr_seq(12'h620);
    look(12'h140, 12'h140, 12'h140, 1'b0, "R9 index write wins");
  endtask

  task automatic t_midtriple();
    wr_idx(30, 1'b0, '0);
    wr_seq(12'h901); wr_seq(12'h902);
    wr_idx(31, 1'b0, '0);
    wr_seq(12'h911);
    look(12'h1E0, 12'h1E0, 12'h1E0, 1'b0, "R2 partial index 30");
    look(12'h1F0, 12'h1F0, 12'h1F0, 1'b0, "R2 pointer back to red at 31");
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 3; c++)
      for (int i = 0; i < 256; i++) ref_mem[c][i] = '0;
    t_reset();
    t_full_load();
    t_mask();
    t_power();
    t_bypass();
    t_hold();
    t_priority();
    t_midtriple();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule